// File: doc/BRIEF.md
# CKE Power-State Tracker

This block follows the power state of a DDR3-style SDRAM device one clock edge at a time. On every rising edge it looks at the clock-enable level on that edge and on the edge before it, at the already decoded command, and at two bank-status flags. The first flag says that every bank is closed. The second says that a read or write burst is still running. From these inputs it keeps a state code: idle, active, active power-down, precharge power-down or self-refresh.

The block also checks the rules that govern clock-enable transitions. These rules cover the legal commands on entry and exit edges, the quiet windows after leaving a low-power state, the wait after a mode-register command, and the minimum time clock-enable must hold a level. When a rule is broken, the block raises a one-cycle error pulse with a cause code and sets a sticky flag. The sticky flag stays set until software-side logic clears it.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake and no back-pressure apply. Every output is registered, so the effect of the inputs sampled on edge N is visible after edge N.

Top module: `dram_pwr_tracker`

Command codes on `cmd`: 0 NOP, 1 DESELECT, 2 REFRESH, 3 READ, 4 WRITE, 5 ODT-related, 6 mode-register write, 7 any other command. State codes on `pwr_state`: 0 idle, 1 active, 2 active power-down, 3 precharge power-down, 4 self-refresh. A "quiet" command is NOP or DESELECT. Edge pairs are written (previous CKE, current CKE).

## Requirements
- R1: While reset is asserted, and after it is released until the first edge, `pwr_state` is 0, `err_pulse` is 0, `err_cause` is 0 and `err_sticky` is 0. The previous CKE sample resets to high.
- R2: On a (high, high) edge, the state becomes 0 (idle) when `banks_closed` is 1, otherwise 1 (active).
- R3: On a (high, low) edge with a quiet command, the state becomes 3 (precharge power-down) when `banks_closed` is 1, otherwise 2 (active power-down).
- R4: On a (high, low) edge with REFRESH, the state becomes 4 (self-refresh) when the current state is idle, `banks_closed` is 1 and `burst_busy` is 0.
- R5: On a (high, low) edge with REFRESH, the block reports cause 4 if `burst_busy` is 1. Otherwise it reports cause 5 if the state is not idle or `banks_closed` is 0. In both cases the state enters the power-down flavour of R3 instead of self-refresh.
- R6: A (high, low) edge with a command that is neither quiet nor REFRESH, or a (low, high) edge with a command that is not quiet, reports cause 3. The state transition still takes place.
- R7: On a (low, low) edge the state is unchanged and no error is reported, whatever the command and bank flags.
- R8: After a (low, high) edge out of self-refresh, a non-quiet command on any of the next TXS edges reports cause 6.
- R9: After a self-refresh exit edge, a READ or ODT command on any of the next TXSDLL edges that is outside the R8 window reports cause 7. The same command is accepted afterwards.
- R10: After a (low, high) edge out of either power-down state, a non-quiet command on any of the next TXP edges reports cause 6.
- R11: After an edge carrying a mode-register write, a (high, low) edge on any of the next TMOD edges reports cause 2.
- R12: After any CKE level change, a further level change on any of the next TCKEMIN-1 edges reports cause 1.
- R13: Each edge reports at most one cause. The lowest-numbered violated cause wins. `err_pulse` is 1 exactly on the cycles after an edge that reports a non-zero cause.
- R14: `err_sticky` is set by any reported cause and holds until an edge with `err_clr` at 1. If a cause is reported on the same edge as the clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level on the current edge |
| cmd | input | 3 | Decoded command code for the current edge |
| banks_closed | input | 1 | All banks are closed and precharge timing is met |
| burst_busy | input | 1 | A read or write burst is in progress |
| err_clr | input | 1 | Clears the sticky error flag |
| pwr_state | output | 3 | Current power-state code |
| err_pulse | output | 1 | One-cycle flag for a rule violation on the last edge |
| err_cause | output | 3 | Cause code of that violation, 0 when none |
| err_sticky | output | 1 | Latched error flag |

## Verification
The state machine is driven through each of the four CKE edge pairs. Each pair is tried with both settings of `banks_closed`, which separates the active and precharge power-down flavours and the idle and active normal states. Each exit is followed by commands placed on the first edge, the last edge and the first edge past every window (TXS, TXSDLL, TXP, TMOD, TCKEMIN). These cases separate an off-by-one window from a correct one, and tell an exit-window error apart from a DLL-wait error. The REFRESH entry is tried from a clean idle state, with a burst running, from the active state, and with both faults at once to check cause priority. The sticky flag is checked for clearing alone and for a clear that meets a fresh error.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_DESEL = 3'd1,
    CMD_REF   = 3'd2,
    CMD_RD    = 3'd3,
    CMD_WR    = 3'd4,
    CMD_ODT   = 3'd5,
    CMD_MRS   = 3'd6,
    CMD_OTHER = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    PS_IDLE     = 3'd0,
    PS_ACTIVE   = 3'd1,
    PS_ACT_PD   = 3'd2,
    PS_PRE_PD   = 3'd3,
    PS_SELF_REF = 3'd4
  } pstate_e;

  // lower code = higher priority
  typedef enum logic [2:0] {
    ER_NONE       = 3'd0,
    ER_CKE_PULSE  = 3'd1,
    ER_MOD_WAIT   = 3'd2,
    ER_EDGE_CMD   = 3'd3,
    ER_SR_BURST   = 3'd4,
    ER_SR_NOTIDLE = 3'd5,
    ER_EXIT_WAIT  = 3'd6,
    ER_DLL_WAIT   = 3'd7
  } err_e;

  typedef enum logic [1:0] {
    EDGE_HIGH  = 2'd0,
    EDGE_ENTER = 2'd1,
    EDGE_LOW   = 2'd2,
    EDGE_EXIT  = 2'd3
  } edge_e;

  // indices of the wait-window counters
  localparam int W_XS    = 0;
  localparam int W_DLL   = 1;
  localparam int W_XP    = 2;
  localparam int W_MOD   = 3;
  localparam int N_WAITS = 4;

  function automatic logic is_quiet(input logic [2:0] c);
    return (c == CMD_NOP) || (c == CMD_DESEL);
  endfunction

endpackage

// File: rtl/dram_wait_ctr.sv
// Down-counter that marks a window of MAXV edges following a load edge.
module dram_wait_ctr #(
  parameter int unsigned MAXV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int W = $clog2(MAXV + 2);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= W'(MAXV);
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dram_cke_edge.sv
// Classifies the CKE sample pair and checks the minimum level hold time.
module dram_cke_edge
  import dram_pwr_pkg::*;
#(
  parameter int unsigned TCKEMIN = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cke,
  output edge_e edge_kind,
  output logic  pulse_err
);
  logic cke_q;
  logic changed;
  logic hold_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign changed = cke ^ cke_q;

  dram_wait_ctr #(.MAXV(TCKEMIN - 1)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (changed),
    .busy  (hold_busy)
  );

  assign pulse_err = changed && hold_busy;

  always_comb begin
    unique case ({cke_q, cke})
      2'b11:   edge_kind = EDGE_HIGH;
      2'b10:   edge_kind = EDGE_ENTER;
      2'b00:   edge_kind = EDGE_LOW;
      default: edge_kind = EDGE_EXIT;
    endcase
  end
endmodule

// File: rtl/dram_pwr_fsm.sv
// Power-state register plus the per-edge rule checks.
module dram_pwr_fsm
  import dram_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  edge_e              edge_kind,
  input  logic               pulse_err,
  input  logic [2:0]         cmd,
  input  logic               banks_closed,
  input  logic               burst_busy,
  input  logic               err_clr,
  input  logic [N_WAITS-1:0] wait_busy,
  output logic [N_WAITS-1:0] wait_load,
  output logic [2:0]         pwr_state,
  output logic               err_pulse,
  output logic [2:0]         err_cause,
  output logic               err_sticky
);
  pstate_e state_q, state_d;
  err_e    cause;
  pstate_e normal_st, pd_st;
  logic    quiet;

  assign quiet     = is_quiet(cmd);
  assign normal_st = banks_closed ? PS_IDLE : PS_ACTIVE;
  assign pd_st     = banks_closed ? PS_PRE_PD : PS_ACT_PD;

  always_comb begin
    state_d   = state_q;
    cause     = ER_NONE;
    wait_load = '0;
    unique case (edge_kind)
      EDGE_HIGH: begin
        state_d = normal_st;
        wait_load[W_MOD] = (cmd == CMD_MRS);
        if ((wait_busy[W_XS] || wait_busy[W_XP]) && !quiet)
          cause = ER_EXIT_WAIT;
        else if (wait_busy[W_DLL] && (cmd == CMD_RD || cmd == CMD_ODT))
          cause = ER_DLL_WAIT;
      end
      EDGE_ENTER: begin
        state_d = pd_st;
        if (cmd == CMD_REF) begin
          if (burst_busy)
            cause = ER_SR_BURST;
          else if (state_q != PS_IDLE || !banks_closed)
            cause = ER_SR_NOTIDLE;
          else
            state_d = PS_SELF_REF;
        end else if (!quiet) begin
          cause = ER_EDGE_CMD;
        end
        if (wait_busy[W_MOD]) cause = ER_MOD_WAIT;
      end
      EDGE_LOW: begin
        state_d = state_q;
      end
      default: begin
        state_d = normal_st;
        if (!quiet) cause = ER_EDGE_CMD;
        if (state_q == PS_SELF_REF) begin
          wait_load[W_XS]  = 1'b1;
          wait_load[W_DLL] = 1'b1;
        end else begin
          wait_load[W_XP]  = 1'b1;
        end
      end
    endcase
    if (pulse_err) cause = ER_CKE_PULSE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= PS_IDLE;
      err_pulse  <= 1'b0;
      err_cause  <= 3'd0;
      err_sticky <= 1'b0;
    end else begin
      state_q    <= state_d;
      err_pulse  <= (cause != ER_NONE);
      err_cause  <= cause;
      err_sticky <= (cause != ER_NONE) || (err_sticky && !err_clr);
    end
  end

  assign pwr_state = state_q;
endmodule

// File: rtl/dram_pwr_tracker.sv
module dram_pwr_tracker
  import dram_pwr_pkg::*;
#(
  parameter int unsigned TXS     = 5,
  parameter int unsigned TXSDLL  = 12,
  parameter int unsigned TXP     = 3,
  parameter int unsigned TCKEMIN = 3,
  parameter int unsigned TMOD    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       banks_closed,
  input  logic       burst_busy,
  input  logic       err_clr,
  output logic [2:0] pwr_state,
  output logic       err_pulse,
  output logic [2:0] err_cause,
  output logic       err_sticky
);
  localparam int unsigned WAIT_LEN [N_WAITS] = '{TXS, TXSDLL, TXP, TMOD};

  edge_e              edge_kind;
  logic               pulse_err;
  logic [N_WAITS-1:0] wait_load;
  logic [N_WAITS-1:0] wait_busy;

  dram_cke_edge #(.TCKEMIN(TCKEMIN)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .edge_kind (edge_kind),
    .pulse_err (pulse_err)
  );

  for (genvar g = 0; g < N_WAITS; g++) begin : g_wait
    dram_wait_ctr #(.MAXV(WAIT_LEN[g])) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wait_load[g]),
      .busy  (wait_busy[g])
    );
  end

  dram_pwr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .edge_kind    (edge_kind),
    .pulse_err    (pulse_err),
    .cmd          (cmd),
    .banks_closed (banks_closed),
    .burst_busy   (burst_busy),
    .err_clr      (err_clr),
    .wait_busy    (wait_busy),
    .wait_load    (wait_load),
    .pwr_state    (pwr_state),
    .err_pulse    (err_pulse),
    .err_cause    (err_cause),
    .err_sticky   (err_sticky)
  );
endmodule

// File: rtl/dram_pwr_tracker_chk.sv
module dram_pwr_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic [2:0] cmd,
  input logic       banks_closed,
  input logic       burst_busy,
  input logic       err_clr,
  input logic [2:0] pwr_state,
  input logic       err_pulse,
  input logic [2:0] err_cause,
  input logic       err_sticky
);
  logic prev_cke;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_cke <= 1'b1;
    else        prev_cke <= cke;
  end

  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state <= 3'd4);

  assert_high_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_cke && cke && banks_closed) |=> (pwr_state == 3'd0));

  assert_pd_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_cke && !cke && cmd <= 3'd1) |=> (pwr_state == 3'd2 || pwr_state == 3'd3));

  assert_sr_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_cke && !cke && cmd == 3'd2 && pwr_state == 3'd0 && banks_closed && !burst_busy)
    |=> (pwr_state == 3'd4));

  assert_sr_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_cke && !cke && cmd == 3'd2 && burst_busy)
    |=> (err_pulse && err_cause <= 3'd4 && pwr_state != 3'd4));

  assert_edge_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((prev_cke != cke) && cmd > 3'd1 && !(prev_cke && cmd == 3'd2)) |=> err_pulse);

  assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_cke && !cke) |=> ($stable(pwr_state) && !err_pulse));

  assert_pulse_sets_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  assert_sticky_holds_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);

  assert_sticky_clears_R14: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (!err_sticky || err_pulse));
endmodule

bind dram_pwr_tracker dram_pwr_tracker_chk u_chk (.*);

// File: tb/test_dram_pwr_tracker.sv
`timescale 1ns/1ps
module test_dram_pwr_tracker;
  localparam logic H = 1'b1;
  localparam logic L = 1'b0;
  localparam logic [2:0] NOP = 3'd0, DES = 3'd1, REF = 3'd2, RD = 3'd3,
                         WR = 3'd4, ODT = 3'd5, MRS = 3'd6, OTH = 3'd7;
  localparam logic [2:0] S_I = 3'd0, S_A = 3'd1, S_APD = 3'd2, S_PPD = 3'd3, S_SR = 3'd4;
  localparam int NV = 61;

  // {req, cke, cmd, banks_closed, burst_busy, exp_state, exp_cause}
  localparam logic [15:0] VEC [NV] = '{
    {4'd2,  H, NOP, H, L, S_I,   3'd0}, // R2 idle
    {4'd2,  H, OTH, L, L, S_A,   3'd0}, // R2 active
    {4'd3,  L, NOP, L, L, S_APD, 3'd0}, // R3 active pd
    {4'd7,  L, RD,  L, L, S_APD, 3'd0}, // R7 cmd ignored
    {4'd7,  L, WR,  H, L, S_APD, 3'd0}, // R7 bank flag ignored
    {4'd6,  H, NOP, L, L, S_A,   3'd0}, // R6 legal exit
    {4'd10, H, NOP, L, L, S_A,   3'd0}, // R10 k1
    {4'd10, H, NOP, L, L, S_A,   3'd0}, // R10 k2
    {4'd10, H, RD,  L, L, S_A,   3'd6}, // R10 k3 last edge of window
    {4'd10, H, WR,  L, L, S_A,   3'd0}, // R10 past window
    {4'd2,  H, OTH, H, L, S_I,   3'd0}, // R2
    {4'd3,  L, DES, H, L, S_PPD, 3'd0}, // R3 precharge pd
    {4'd7,  L, NOP, H, L, S_PPD, 3'd0}, // R7
    {4'd7,  L, NOP, H, L, S_PPD, 3'd0}, // R7
    {4'd6,  H, DES, H, L, S_I,   3'd0}, // R6
    {4'd10, H, NOP, H, L, S_I,   3'd0}, // R10
    {4'd10, H, NOP, H, L, S_I,   3'd0}, // R10
    {4'd10, H, NOP, H, L, S_I,   3'd0}, // R10
    {4'd4,  L, REF, H, L, S_SR,  3'd0}, // R4 self-refresh entry
    {4'd7,  L, NOP, H, L, S_SR,  3'd0}, // R7
    {4'd7,  L, NOP, H, L, S_SR,  3'd0}, // R7
    {4'd6,  H, NOP, H, L, S_I,   3'd0}, // R6 self-refresh exit
    {4'd8,  H, NOP, H, L, S_I,   3'd0}, // R8 k1
    {4'd8,  H, NOP, H, L, S_I,   3'd0}, // R8 k2
    {4'd8,  H, REF, H, L, S_I,   3'd6}, // R8 k3
    {4'd8,  H, NOP, H, L, S_I,   3'd0}, // R8 k4
    {4'd8,  H, WR,  H, L, S_I,   3'd6}, // R8 k5 last edge
    {4'd9,  H, RD,  H, L, S_I,   3'd7}, // R9 k6
    {4'd9,  H, ODT, H, L, S_I,   3'd7}, // R9 k7
    {4'd9,  H, NOP, H, L, S_I,   3'd0}, // R9 k8
    {4'd9,  H, NOP, H, L, S_I,   3'd0}, // R9 k9
    {4'd9,  H, NOP, H, L, S_I,   3'd0}, // R9 k10
    {4'd9,  H, NOP, H, L, S_I,   3'd0}, // R9 k11
    {4'd9,  H, RD,  H, L, S_I,   3'd7}, // R9 k12 last edge
    {4'd9,  H, RD,  H, L, S_I,   3'd0}, // R9 k13 accepted
    {4'd11, H, MRS, H, L, S_I,   3'd0}, // R11 mode write
    {4'd11, H, NOP, H, L, S_I,   3'd0}, // R11
    {4'd11, H, NOP, H, L, S_I,   3'd0}, // R11
    {4'd11, H, NOP, H, L, S_I,   3'd0}, // R11
    {4'd11, L, NOP, H, L, S_PPD, 3'd2}, // R11 fall on last blocked edge
    {4'd7,  L, NOP, H, L, S_PPD, 3'd0}, // R7
    {4'd7,  L, NOP, H, L, S_PPD, 3'd0}, // R7
    {4'd6,  H, NOP, H, L, S_I,   3'd0}, // R6
    {4'd10, H, NOP, H, L, S_I,   3'd0}, // R10
    {4'd10, H, NOP, H, L, S_I,   3'd0}, // R10
    {4'd10, H, NOP, H, L, S_I,   3'd0}, // R10
    {4'd11, H, MRS, H, L, S_I,   3'd0}, // R11
    {4'd11, H, NOP, H, L, S_I,   3'd0}, // R11
    {4'd11, H, NOP, H, L, S_I,   3'd0}, // R11
    {4'd11, H, NOP, H, L, S_I,   3'd0}, // R11
    {4'd11, H, NOP, H, L, S_I,   3'd0}, // R11
    {4'd11, L, NOP, H, L, S_PPD, 3'd0}, // R11 first legal fall
    {4'd12, H, NOP, H, L, S_I,   3'd1}, // R12 pulse too short
    {4'd12, H, NOP, H, L, S_I,   3'd0}, // R12
    {4'd12, L, NOP, H, L, S_PPD, 3'd1}, // R12 last blocked edge
    {4'd7,  L, NOP, H, L, S_PPD, 3'd0}, // R7
    {4'd7,  L, NOP, H, L, S_PPD, 3'd0}, // R7
    {4'd12, H, NOP, H, L, S_I,   3'd0}, // R12 first legal change
    {4'd10, H, NOP, H, L, S_I,   3'd0}, // R10
    {4'd10, H, NOP, H, L, S_I,   3'd0}, // R10
    {4'd10, H, NOP, H, L, S_I,   3'd0}  // R10
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cke;
  logic [2:0] cmd;
  logic       banks_closed;
  logic       burst_busy;
  logic       err_clr;
  logic [2:0] pwr_state;
  logic       err_pulse;
  logic [2:0] err_cause;
  logic       err_sticky;

  int  n_chk  = 0;
  int  n_fail = 0;
  logic sticky_m = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  dram_pwr_tracker #(.TXS(5), .TXSDLL(12), .TXP(3), .TCKEMIN(3), .TMOD(4)) i_dram_pwr_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .banks_closed(banks_closed),
    .burst_busy(burst_busy), .err_clr(err_clr), .pwr_state(pwr_state),
    .err_pulse(err_pulse), .err_cause(err_cause), .err_sticky(err_sticky)
  );

  task automatic chk(input logic [2:0] es, input logic [2:0] ec, input logic esticky,
                     input string req);
    n_chk++;
    if (pwr_state !== es || err_cause !== ec || err_pulse !== (ec != 3'd0) ||
        err_sticky !== esticky) begin
      n_fail++;
      $display("FAIL %s: actual state=%0d cause=%0d pulse=%0b sticky=%0b expected state=%0d cause=%0d pulse=%0b sticky=%0b",
               req, pwr_state, err_cause, err_pulse, err_sticky, es, ec, (ec != 3'd0), esticky);
    end
  endtask

  // drive at negedge, let one rising edge sample, check at the next negedge
  task automatic step(input logic c, input logic [2:0] m, input logic cl, input logic bu,
                      input logic clr, input logic [2:0] es, input logic [2:0] ec,
                      input string req);
    cke = c; cmd = m; banks_closed = cl; burst_busy = bu; err_clr = clr;
    @(posedge clk);
    @(negedge clk);
    sticky_m = (ec != 3'd0) || (sticky_m && !clr);
    chk(es, ec, sticky_m, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cke = 1'b1; cmd = NOP; banks_closed = 1'b1; burst_busy = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    sticky_m = 1'b0;
    chk(S_I, 3'd0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic low_exit_drain(input logic cl, input logic [2:0] pd, input logic [2:0] nm);
    step(L, NOP, cl, L, L, pd, 3'd0, "R7");
    step(L, NOP, cl, L, L, pd, 3'd0, "R7");
    step(H, NOP, cl, L, L, nm, 3'd0, "R6");
    for (int k = 0; k < 3; k++) step(H, NOP, cl, L, L, nm, 3'd0, "R10");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(S_I, 3'd0, 1'b0, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      step(v[11], v[10:8], v[7], v[6], 1'b0, v[5:3], v[2:0], $sformatf("R%0d row %0d", v[15:12], i));
    end

    // reset after errors clears everything (R1)
    do_reset();

    // R5: refresh entry with a burst running
    step(H, NOP, H, H, L, S_I, 3'd0, "R2");
    step(L, REF, H, H, L, S_PPD, 3'd4, "R5 burst");
    low_exit_drain(H, S_PPD, S_I);

    // R5: refresh entry from the active state
    step(H, OTH, L, L, L, S_A, 3'd0, "R2");
    step(L, REF, L, L, L, S_APD, 3'd5, "R5 not idle");
    low_exit_drain(L, S_APD, S_A);

    // R13: burst and not idle together, lower code wins
    step(H, OTH, L, L, L, S_A, 3'd0, "R2");
    step(L, REF, L, H, L, S_APD, 3'd4, "R13 priority 4 over 5");
    low_exit_drain(L, S_APD, S_A);

    // R6: bad commands on entry and exit edges
    step(H, NOP, H, L, L, S_I, 3'd0, "R2");
    step(L, WR, H, L, L, S_PPD, 3'd3, "R6 entry");
    step(L, NOP, H, L, L, S_PPD, 3'd0, "R7");
    step(L, NOP, H, L, L, S_PPD, 3'd0, "R7");
    step(H, RD, H, L, L, S_I, 3'd3, "R6 exit");
    for (int k = 0; k < 3; k++) step(H, NOP, H, L, L, S_I, 3'd0, "R10");

    // R13: mode wait outranks a bad entry command
    step(H, MRS, H, L, L, S_I, 3'd0, "R11");
    step(L, RD, H, L, L, S_PPD, 3'd2, "R13 priority 2 over 3");
    low_exit_drain(H, S_PPD, S_I);

    // R14: clear alone, then clear meeting a new error
    step(H, NOP, H, L, H, S_I, 3'd0, "R14 clear");
    step(H, MRS, H, L, L, S_I, 3'd0, "R11");
    step(L, NOP, H, L, H, S_PPD, 3'd2, "R14 set wins over clear");
    step(L, NOP, H, L, L, S_PPD, 3'd0, "R14 holds");
    step(L, NOP, H, L, L, S_PPD, 3'd0, "R14 holds");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule